// File: doc/BRIEF.md
# Backplane Transfer Allocator

This block decides, once per epoch, which cards on a switched backplane may move data to which other cards. Each card acts as a source with one request line per possible destination. Each card also acts as a destination with an inhibit line that it raises when it cannot take data, and it marks with a flag whether it is a forwarding-engine card. The allocator picks a set of source-to-destination pairs in which no source and no destination is used twice. It publishes that set as two views: one per source (the destination to drive) and one per destination (the source to listen to). The set is tagged with an epoch number.

The work is pipelined across epochs. Requests, inhibits and flags are sampled at the end of one epoch. The allocation is computed in parallel during the next epoch and published at its end. The cards then have a full epoch to configure themselves before the data moves. Fairness comes from a pseudo-random rotation of the source and destination scan order, which changes every epoch. Forwarding-engine sources are always served ahead of line cards. A source that loses simply keeps its request up and competes again.

Top module: `bp_allocator`

## Requirements
- R1: While reset is asserted and until the first publication after it, all grant bits, all index fields, the strobe and the epoch tag are zero.
- R2: An epoch lasts TICKS clock cycles. `grant_stb_o` is high for exactly one cycle per epoch, TICKS cycles after the previous pulse. All grant outputs and the tag hold their values between pulses.
- R3: The request, inhibit and flag values present on the clock edge that ends epoch k are the ones used for the grants published on the edge that ends epoch k+1. Those grants are seen together with the strobe in the first cycle of epoch k+2.
- R4: Grants are conflict-free. Each granted source s has `dst_gnt_o[d]` set and `dst_src_o` field d equal to s, where d is its destination field. Both views hold the same number of grants. The field of source s sits at bits s*IW upward, where IW = clog2(N_CARDS). Fields of ungranted entries are zero.
- R5: A pair (s,d) is granted only if bit s*N_CARDS+d of the sampled request matrix was set.
- R6: No destination whose inhibit bit was sampled high is granted in that allocation.
- R7: All sources whose flag bit was sampled high are scanned before any source with the flag low. A line card therefore never takes a destination that a flagged source requested and could have had.
- R8: Within each class, sources are scanned in the order so, so+1, … modulo N_CARDS. Each scanned source takes the first destination in the order do, do+1, … modulo N_CARDS that it requested, that is not inhibited and that is still free.
- R9: A 16-bit shift register starts at 0xACE1 after reset. It shifts left once per epoch end, feeding in bit15^bit13^bit12^bit10. An allocation uses the value held before that shift, with so = bits[7:0] mod N_CARDS and do = bits[15:8] mod N_CARDS.
- R10: The epoch tag increases by one, modulo 2^EPOCH_W, with every strobe.
- R11: When several line-card sources keep asking for the same single destination over many epochs, each of them is granted at some point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Allocation clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | N_CARDS*N_CARDS | Request matrix, bit s*N_CARDS+d = source s wants destination d |
| inhibit_i | input | N_CARDS | Destination cannot accept data |
| fe_i | input | N_CARDS | Source is a forwarding-engine card |
| src_gnt_o | output | N_CARDS | Source granted this epoch |
| src_dst_o | output | N_CARDS*IW | Destination index per source |
| dst_gnt_o | output | N_CARDS | Destination granted this epoch |
| dst_src_o | output | N_CARDS*IW | Source index per destination |
| grant_stb_o | output | 1 | One-cycle pulse when new grants are published |
| epoch_o | output | EPOCH_W | Tag of the published allocation |

## Verification
Single isolated requests, one for every source and destination pair, show the two-epoch latency and the index encoding without any contention. A full request matrix under every inhibit pattern separates correct inhibit masking from a plain greedy fill. Every source asking for one destination under every flag pattern shows whether flagged sources really come first. The same contention with no flags, held for many epochs, shows whether the rotation spreads wins. Pseudo-random mixes of all three inputs compare every published grant against an arithmetic model of the rotated scan.

// File: rtl/bp_alloc_pkg.sv
package bp_alloc_pkg;

  localparam int SHUF_W = 16;
  localparam logic [SHUF_W-1:0] SHUF_SEED = 16'hACE1;

  function automatic logic [SHUF_W-1:0] shuf_step(input logic [SHUF_W-1:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

endpackage

// File: rtl/bpa_epoch_timer.sv
module bpa_epoch_timer #(
  parameter int TICKS = 8,
  localparam int CW = (TICKS > 2) ? $clog2(TICKS) : 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic epoch_end_o
);

  logic [CW-1:0] tick_q, tick_d;

  assign epoch_end_o = (tick_q == CW'(TICKS - 1));

  always_comb begin
    tick_d = epoch_end_o ? '0 : tick_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_q <= '0;
    else        tick_q <= tick_d;
  end

endmodule

// File: rtl/bpa_shuffler.sv
module bpa_shuffler
  import bp_alloc_pkg::*;
#(
  parameter int N_CARDS = 15,
  localparam int IW = $clog2(N_CARDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_i,
  output logic [IW-1:0] src_off_o,
  output logic [IW-1:0] dst_off_o
);

  logic [SHUF_W-1:0] st_q, st_d;

  assign src_off_o = IW'(st_q[7:0] % 8'(N_CARDS));
  assign dst_off_o = IW'(st_q[15:8] % 8'(N_CARDS));

  always_comb begin
    st_d = st_q;
    if (adv_i) st_d = shuf_step(st_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SHUF_SEED;
    else        st_q <= st_d;
  end

endmodule

// File: rtl/bpa_matcher.sv
module bpa_matcher #(
  parameter int N_CARDS = 15,
  localparam int IW = $clog2(N_CARDS),
  localparam int NN = N_CARDS * N_CARDS
) (
  input  logic [NN-1:0]         req_i,
  input  logic [N_CARDS-1:0]    inh_i,
  input  logic [N_CARDS-1:0]    fe_i,
  input  logic [IW-1:0]         src_off_i,
  input  logic [IW-1:0]         dst_off_i,
  output logic [N_CARDS-1:0]    src_gnt_o,
  output logic [N_CARDS*IW-1:0] src_dst_o,
  output logic [N_CARDS-1:0]    dst_gnt_o,
  output logic [N_CARDS*IW-1:0] dst_src_o
);

  function automatic int rot(input int base, input int k);
    return (base + k) % N_CARDS;
  endfunction

  always_comb begin
    src_gnt_o = '0;
    dst_gnt_o = '0;
    src_dst_o = '0;
    dst_src_o = '0;
    for (int p = 0; p < 2; p++) begin
      for (int i = 0; i < N_CARDS; i++) begin
        for (int j = 0; j < N_CARDS; j++) begin
          if (((p == 0) == fe_i[rot(int'(src_off_i), i)]) &&
              !src_gnt_o[rot(int'(src_off_i), i)] &&
              req_i[rot(int'(src_off_i), i) * N_CARDS + rot(int'(dst_off_i), j)] &&
              !inh_i[rot(int'(dst_off_i), j)] &&
              !dst_gnt_o[rot(int'(dst_off_i), j)]) begin
            src_gnt_o[rot(int'(src_off_i), i)] = 1'b1;
            dst_gnt_o[rot(int'(dst_off_i), j)] = 1'b1;
            src_dst_o[rot(int'(src_off_i), i) * IW +: IW] = IW'(rot(int'(dst_off_i), j));
            dst_src_o[rot(int'(dst_off_i), j) * IW +: IW] = IW'(rot(int'(src_off_i), i));
          end
        end
      end
    end
  end

endmodule

// File: rtl/bp_allocator.sv
module bp_allocator #(
  parameter int N_CARDS = 15,
  parameter int TICKS   = 8,
  parameter int EPOCH_W = 8,
  localparam int IW = $clog2(N_CARDS),
  localparam int NN = N_CARDS * N_CARDS
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NN-1:0]           req_i,
  input  logic [N_CARDS-1:0]      inhibit_i,
  input  logic [N_CARDS-1:0]      fe_i,
  output logic [N_CARDS-1:0]      src_gnt_o,
  output logic [N_CARDS*IW-1:0]   src_dst_o,
  output logic [N_CARDS-1:0]      dst_gnt_o,
  output logic [N_CARDS*IW-1:0]   dst_src_o,
  output logic                    grant_stb_o,
  output logic [EPOCH_W-1:0]      epoch_o
);

  logic rst_meta_n, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  logic          epoch_end;
  logic [IW-1:0] src_off, dst_off;

  bpa_epoch_timer #(.TICKS(TICKS)) u_timer (
    .clk(clk), .rst_n(rst_sync_n), .epoch_end_o(epoch_end)
  );

  bpa_shuffler #(.N_CARDS(N_CARDS)) u_shuf (
    .clk(clk), .rst_n(rst_sync_n), .adv_i(epoch_end),
    .src_off_o(src_off), .dst_off_o(dst_off)
  );

  // request stage registers
  logic [NN-1:0]      cap_req_q, cap_req_d;
  logic [N_CARDS-1:0] cap_inh_q, cap_inh_d;
  logic [N_CARDS-1:0] cap_fe_q,  cap_fe_d;

  // allocation result
  logic [N_CARDS-1:0]    m_src_gnt, m_dst_gnt;
  logic [N_CARDS*IW-1:0] m_src_dst, m_dst_src;

  bpa_matcher #(.N_CARDS(N_CARDS)) u_match (
    .req_i(cap_req_q), .inh_i(cap_inh_q), .fe_i(cap_fe_q),
    .src_off_i(src_off), .dst_off_i(dst_off),
    .src_gnt_o(m_src_gnt), .src_dst_o(m_src_dst),
    .dst_gnt_o(m_dst_gnt), .dst_src_o(m_dst_src)
  );

  // publication stage registers
  logic [N_CARDS-1:0]    sg_q, sg_d, dg_q, dg_d;
  logic [N_CARDS*IW-1:0] sd_q, sd_d, ds_q, ds_d;
  logic                  stb_q, stb_d;
  logic [EPOCH_W-1:0]    ep_q, ep_d;

  always_comb begin
    cap_req_d = cap_req_q;
    cap_inh_d = cap_inh_q;
    cap_fe_d  = cap_fe_q;
    sg_d = sg_q;
    dg_d = dg_q;
    sd_d = sd_q;
    ds_d = ds_q;
    ep_d = ep_q;
    stb_d = epoch_end;
    if (epoch_end) begin
      cap_req_d = req_i;
      cap_inh_d = inhibit_i;
      cap_fe_d  = fe_i;
      sg_d = m_src_gnt;
      dg_d = m_dst_gnt;
      sd_d = m_src_dst;
      ds_d = m_dst_src;
      ep_d = ep_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cap_req_q <= '0;
      cap_inh_q <= '0;
      cap_fe_q  <= '0;
      sg_q  <= '0;
      dg_q  <= '0;
      sd_q  <= '0;
      ds_q  <= '0;
      stb_q <= 1'b0;
      ep_q  <= '0;
    end else begin
      cap_req_q <= cap_req_d;
      cap_inh_q <= cap_inh_d;
      cap_fe_q  <= cap_fe_d;
      sg_q  <= sg_d;
      dg_q  <= dg_d;
      sd_q  <= sd_d;
      ds_q  <= ds_d;
      stb_q <= stb_d;
      ep_q  <= ep_d;
    end
  end

  assign src_gnt_o   = sg_q;
  assign dst_gnt_o   = dg_q;
  assign src_dst_o   = sd_q;
  assign dst_src_o   = ds_q;
  assign grant_stb_o = stb_q;
  assign epoch_o     = ep_q;

endmodule

// File: rtl/bp_allocator_chk.sv
module bp_allocator_chk #(
  parameter int N_CARDS = 15,
  parameter int TICKS   = 8,
  parameter int EPOCH_W = 8,
  localparam int IW = $clog2(N_CARDS),
  localparam int NN = N_CARDS * N_CARDS,
  localparam int CW = $clog2(TICKS + 1)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NN-1:0]         req_i,
  input logic [N_CARDS-1:0]    inhibit_i,
  input logic [N_CARDS-1:0]    src_gnt_o,
  input logic [N_CARDS*IW-1:0] src_dst_o,
  input logic [N_CARDS-1:0]    dst_gnt_o,
  input logic [N_CARDS*IW-1:0] dst_src_o,
  input logic                  grant_stb_o,
  input logic [EPOCH_W-1:0]    epoch_o
);

  logic [CW-1:0]      cnt;
  logic               started;
  logic [NN-1:0]      rq1, rq2;
  logic [N_CARDS-1:0] ih1, ih2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; started <= 1'b0;
      rq1 <= '0; rq2 <= '0; ih1 <= '0; ih2 <= '0;
    end else begin
      cnt <= (cnt == CW'(TICKS - 1)) ? '0 : cnt + 1'b1;
      if (cnt == CW'(TICKS - 1)) begin
        started <= 1'b1;
        rq1 <= req_i;  rq2 <= rq1;
        ih1 <= inhibit_i; ih2 <= ih1;
      end
    end
  end

  a_r2_stb_only_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    grant_stb_o |-> (cnt == '0 && started));
  a_r2_stb_every_epoch: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && started) |-> grant_stb_o);
  a_r2_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_stb_o |-> ($stable(src_gnt_o) && $stable(dst_gnt_o) && $stable(epoch_o)));
  a_r10_tag_step: assert property (@(posedge clk) disable iff (!rst_n)
    grant_stb_o |-> (epoch_o == $past(epoch_o) + 1'b1));
  a_r4_equal_counts: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(src_gnt_o) == $countones(dst_gnt_o));
  a_r6_no_inhibited: assert property (@(posedge clk) disable iff (!rst_n)
    grant_stb_o |-> ((dst_gnt_o & ih2) == '0));

  for (genvar s = 0; s < N_CARDS; s++) begin : g_src
    a_r4_pair_consistent: assert property (@(posedge clk) disable iff (!rst_n)
      src_gnt_o[s] |-> (dst_gnt_o[src_dst_o[s*IW +: IW]] &&
                        dst_src_o[src_dst_o[s*IW +: IW]*IW +: IW] == IW'(s)));
    a_r5_was_requested: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_stb_o && src_gnt_o[s]) |-> rq2[s*N_CARDS + int'(src_dst_o[s*IW +: IW])]);
  end

endmodule

bind bp_allocator bp_allocator_chk #(
  .N_CARDS(N_CARDS), .TICKS(TICKS), .EPOCH_W(EPOCH_W)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .req_i(req_i), .inhibit_i(inhibit_i),
  .src_gnt_o(src_gnt_o), .src_dst_o(src_dst_o), .dst_gnt_o(dst_gnt_o),
  .dst_src_o(dst_src_o), .grant_stb_o(grant_stb_o), .epoch_o(epoch_o)
);

// File: tb/bp_allocator_test.sv
module bp_allocator_test;

  localparam int N  = 5;
  localparam int TK = 4;
  localparam int EW = 8;
  localparam int IW = $clog2(N);
  localparam int NN = N * N;

  logic clk = 1'b0;
  logic rst_n;
  logic [NN-1:0] req;
  logic [N-1:0]  inh, fe;
  logic [N-1:0]  src_gnt, dst_gnt;
  logic [N*IW-1:0] src_dst, dst_src;
  logic stb;
  logic [EW-1:0] epoch;

  always #5 clk = ~clk;

  bp_allocator #(.N_CARDS(N), .TICKS(TK), .EPOCH_W(EW)) uut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .inhibit_i(inh), .fe_i(fe),
    .src_gnt_o(src_gnt), .src_dst_o(src_dst), .dst_gnt_o(dst_gnt),
    .dst_src_o(dst_src), .grant_stb_o(stb), .epoch_o(epoch)
  );

  int tests = 0, fails = 0;
  bit done = 0;

  // bench model state
  logic [15:0]   lf_m;
  logic [NN-1:0] cq;
  logic [N-1:0]  ci, cf;
  logic [EW-1:0] ep_m;
  bit first_epoch;
  int wins [N];
  bit count_wins;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected allocation from the rotated two-class scan
  task automatic model(output logic [N-1:0] sg, output logic [N*IW-1:0] sd,
                       output logic [N-1:0] dg, output logic [N*IW-1:0] ds);
    int so, dof;
    so  = int'(lf_m[7:0]) % N;
    dof = int'(lf_m[15:8]) % N;
    sg = '0; dg = '0; sd = '0; ds = '0;
    for (int cls = 1; cls >= 0; cls--) begin
      for (int k = 0; k < N; k++) begin
        int s;
        s = (so + k) % N;
        if (cf[s] == cls[0]) begin
          for (int m = 0; m < N; m++) begin
            int d;
            d = (dof + m) % N;
            if (!sg[s] && cq[s*N+d] && !ci[d] && !dg[d]) begin
              sg[s] = 1'b1; dg[d] = 1'b1;
              sd[s*IW +: IW] = IW'(d);
              ds[d*IW +: IW] = IW'(s);
            end
          end
        end
      end
    end
  endtask

  task automatic run_epoch(input logic [NN-1:0] nreq, input logic [N-1:0] ninh,
                           input logic [N-1:0] nfe, input string tag);
    int cyc;
    logic [N-1:0] esg, edg;
    logic [N*IW-1:0] esd, eds;
    logic [N-1:0] hold_sg;
    logic [EW-1:0] hold_ep;
    bit stable_ok;
    cyc = 0;
    stable_ok = 1;
    hold_sg = src_gnt;
    hold_ep = epoch;
    do begin
      @(negedge clk);
      cyc++;
      if (!stb && (src_gnt !== hold_sg || epoch !== hold_ep)) stable_ok = 0;
    end while (!stb);
    if (!first_epoch) begin
      chk(cyc == TK, "R2 strobe period", 64'(cyc), 64'(TK));
      chk(stable_ok, "R2 outputs held between strobes", 64'(epoch), 64'(hold_ep));
    end
    first_epoch = 0;
    model(esg, esd, edg, eds);
    ep_m = ep_m + 1'b1;
    chk(src_gnt === esg && src_dst === esd, {tag, " source view"},
        64'({src_gnt, src_dst}), 64'({esg, esd}));
    chk(dst_gnt === edg && dst_src === eds, {tag, " destination view"},
        64'({dst_gnt, dst_src}), 64'({edg, eds}));
    chk(epoch === ep_m, "R10 epoch tag", 64'(epoch), 64'(ep_m));
    chk((dst_gnt & ci) == '0, "R6 inhibited destination granted", 64'(dst_gnt), 64'(dst_gnt & ~ci));
    for (int s = 0; s < N; s++) begin
      if (src_gnt[s]) begin
        int d;
        d = int'(src_dst[s*IW +: IW]);
        chk(cq[s*N+d] === 1'b1, "R5 unrequested pair", 64'(s*N+d), 64'(1));
        chk(dst_gnt[d] && dst_src[d*IW +: IW] == IW'(s), "R4 views disagree",
            64'(dst_src[d*IW +: IW]), 64'(s));
      end else begin
        chk(src_dst[s*IW +: IW] == '0, "R4 ungranted field nonzero", 64'(src_dst[s*IW +: IW]), 64'(0));
      end
      if (count_wins && src_gnt[s]) wins[s]++;
    end
    // advance the model and latch what the design samples at this boundary
    lf_m = {lf_m[14:0], lf_m[15] ^ lf_m[13] ^ lf_m[12] ^ lf_m[10]};
    cq = req; ci = inh; cf = fe;
    req = nreq; inh = ninh; fe = nfe;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int rs;
    logic [NN-1:0] all_to_one;
    rst_n = 1'b0;
    req = '0; inh = '0; fe = '0;
    lf_m = 16'hACE1; cq = '0; ci = '0; cf = '0; ep_m = '0;
    first_epoch = 1; count_wins = 0;
    for (int s = 0; s < N; s++) wins[s] = 0;
    repeat (3) @(negedge clk);
    chk(src_gnt == '0 && dst_gnt == '0 && src_dst == '0 && dst_src == '0,
        "R1 grants in reset", 64'({src_gnt, dst_gnt}), 64'(0));
    chk(stb == 1'b0 && epoch == '0, "R1 strobe and tag in reset", 64'({stb, epoch}), 64'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk(src_gnt == '0 && stb == 1'b0 && epoch == '0, "R1 state after release",
        64'({src_gnt, stb, epoch}), 64'(0));

    // idle epochs
    for (int e = 0; e < 2; e++) run_epoch('0, '0, '0, "R1");
    // every isolated pair: two-epoch latency, index encoding
    for (int p = 0; p < NN; p++) run_epoch(NN'(1) << p, '0, '0, "R3");
    // full matrix against every inhibit pattern
    for (int m = 0; m < (1 << N); m++) run_epoch('1, N'(m), '0, "R6");
    // all sources ask for destination 0 under every flag pattern
    all_to_one = '0;
    for (int s = 0; s < N; s++) all_to_one[s*N] = 1'b1;
    for (int m = 0; m < (1 << N); m++) run_epoch(all_to_one, '0, N'(m), "R7");
    // sustained contention without flags
    for (int e = 0; e < 2; e++) run_epoch(all_to_one, '0, '0, "R8");
    count_wins = 1;
    for (int e = 0; e < 60; e++) run_epoch(all_to_one, '0, '0, "R8");
    count_wins = 0;
    for (int s = 0; s < N; s++)
      chk(wins[s] > 0, "R11 source never granted", 64'(wins[s]), 64'(1));
    // pseudo-random mixes
    rs = 32'h1234567;
    for (int e = 0; e < 150; e++) begin
      logic [NN-1:0] r;
      logic [N-1:0] ri, rf;
      rs = rs ^ (rs << 13); rs = rs ^ (rs >>> 17); rs = rs ^ (rs << 5);
      r = NN'(rs);
      rs = rs ^ (rs << 13); rs = rs ^ (rs >>> 17); rs = rs ^ (rs << 5);
      ri = N'(rs) & N'(rs >> 7);
      rf = N'(rs >> 12);
      run_epoch(r, ri, rf, "R9");
    end
    for (int e = 0; e < 2; e++) run_epoch('0, '0, '0, "R8");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule